// File: doc/BRIEF.md
# Self-Correcting Divide-by-Three Clock Generator

This block derives a clock at one third of its input frequency from a pair of rising-edge flip-flops wired as a two-stage shift register. The leading stage loads the NOR of both stages. The legal state cycle has three entries. The feedback also pulls every other state back into that cycle, so the divider recovers from an upset on its own and does not need a reset to start.

A parameter selects between two output shapes. In the default shape the divided clock is high for one input period and low for two. In the balanced shape a single flip-flop on the falling edge holds a delayed copy of the leading stage. The output is the OR of the two, which is high for one and a half input periods. A second output, the phase marker, is high during the one input cycle in which a new output period begins. A second parameter decides whether the reset input clears the divider asynchronously or is ignored.

Top module: `div3_clkgen`

## Requirements
- R1: The state pair (lead, trail) steps through 00, 10, 01 and back to 00 on successive rising edges of `clk_in`. In steady running `phase_mark` is therefore high in exactly one of every three input cycles.
- R2: With `HALF_DUTY` = 0, `clk_out` equals the lead stage. It goes high on the rising edge that enters state 10, stays high for one input period, stays low for two, and changes only just after rising edges.
- R3: With `HALF_DUTY` = 1, `clk_out` goes high on the rising edge that enters state 10. It goes low on the falling edge that follows the next rising edge. This gives 1.5 input periods high and 1.5 low.
- R4: `phase_mark` is high exactly while the state is 10 (lead 1, trail 0). It is never high for two input cycles in a row.
- R5: From state 11 the divider moves to 01, then 00, then 10 with no reset. The first `phase_mark` pulse therefore starts on the third rising edge.
- R6: From any starting state, a `phase_mark` pulse starts within three rising edges. After that the period is exactly three input cycles.
- R7: With `ASYNC_CLEAR` = 1, raising `rst_in` drives both stages, the falling-edge stage, `clk_out` and `phase_mark` low at once, without waiting for a clock edge. They stay low while `rst_in` is high.
- R8: After `rst_in` falls, the first rising edge enters state 10, so `clk_out` and `phase_mark` both go high on that edge.
- R9: With `ASYNC_CLEAR` = 0, `rst_in` has no effect on `clk_out` or `phase_mark`. The divider keeps counting through a reset pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Clock to be divided; state advances on its rising edge |
| rst_in | input | 1 | Active-high asynchronous clear; has no effect when `ASYNC_CLEAR` = 0 |
| clk_out | output | 1 | Divided clock, with a one-third or a near-half duty cycle |
| phase_mark | output | 1 | High for the one input cycle in which the state is 10 |

## Verification
A wrong feedback term or a swapped shift stage shows at the ports as a `phase_mark` spacing other than three cycles. It can also show as a marker that stays high for two cycles. Either becomes visible within at most three rising edges of the fault. The illegal state 11 cannot be reached through the ports, so the bench plants each of the four states directly into the stages and then follows both outputs edge by edge. A missing stretch stage or one on the wrong clock edge shows up as `clk_out` falling half a period too early or too late. This is caught by sampling at points between both clock edges.

// File: rtl/div3_clkgen.sv
module div3_clkgen #(
  parameter bit HALF_DUTY   = 1'b0,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic clk_in,
  input  logic rst_in,
  output logic clk_out,
  output logic phase_mark
);

  logic qa_q;
  logic qb_q;
  logic qa_d;

  assign qa_d = ~(qa_q | qb_q);

  generate
    if (ASYNC_CLEAR) begin : g_clr
      always_ff @(posedge clk_in or posedge rst_in) begin
        if (rst_in) begin
          qa_q <= 1'b0;
          qb_q <= 1'b0;
        end else begin
          qa_q <= qa_d;
          qb_q <= qa_q;
        end
      end
    end else begin : g_free
      always_ff @(posedge clk_in) begin
        qa_q <= qa_d;
        qb_q <= qa_q;
      end
    end

    if (HALF_DUTY) begin : g_half
      logic qn_q;
      if (ASYNC_CLEAR) begin : g_nclr
        always_ff @(negedge clk_in or posedge rst_in) begin
          if (rst_in) qn_q <= 1'b0;
          else        qn_q <= qa_q;
        end
      end else begin : g_nfree
        always_ff @(negedge clk_in) qn_q <= qa_q;
      end
      assign clk_out = qa_q | qn_q;
    end else begin : g_basic
      assign clk_out = qa_q;
    end
  endgenerate

  assign phase_mark = qa_q & ~qb_q;

  logic [1:0] gap_q;
  always_ff @(posedge clk_in or posedge rst_in) begin
    if (rst_in)              gap_q <= 2'd0;
    else if (phase_mark)     gap_q <= 2'd0;
    else if (gap_q != 2'd3)  gap_q <= gap_q + 2'd1;
  end

  // R4
  phase_single_chk: assert property (@(posedge clk_in) disable iff (rst_in)
    phase_mark |=> !phase_mark);

  // R5 R6
  recover_chk: assert property (@(posedge clk_in) disable iff (rst_in)
    (gap_q == 2'd3) |-> phase_mark);

  // R2 R3
  rise_at_start_chk: assert property (@(posedge clk_in) disable iff (rst_in)
    $rose(clk_out) |-> phase_mark);

  // R3
  low_after_pulse_chk: assert property (@(posedge clk_in) disable iff (rst_in)
    $fell(phase_mark) |-> !clk_out);

endmodule

// File: tb/tb_div3_clkgen.sv
`timescale 1ns/1ps
module tb_div3_clkgen;
  logic clk = 1'b0;
  logic rst;
  logic clk_b, ph_b, clk_h, ph_h, clk_f, ph_f;
  logic fa, fb;
  logic [1:0] bs, hs, fs;
  logic hq;
  bit fvalid;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  div3_clkgen #(.HALF_DUTY(1'b0), .ASYNC_CLEAR(1'b1)) dut
    (.clk_in(clk), .rst_in(rst), .clk_out(clk_b), .phase_mark(ph_b));
  div3_clkgen #(.HALF_DUTY(1'b1), .ASYNC_CLEAR(1'b1)) dut_half
    (.clk_in(clk), .rst_in(rst), .clk_out(clk_h), .phase_mark(ph_h));
  div3_clkgen #(.HALF_DUTY(1'b0), .ASYNC_CLEAR(1'b0)) dut_free
    (.clk_in(clk), .rst_in(rst), .clk_out(clk_f), .phase_mark(ph_f));

  function automatic logic [1:0] nxt(input logic [1:0] s);
    case (s)
      2'b00:   nxt = 2'b10;
      2'b10:   nxt = 2'b01;
      2'b01:   nxt = 2'b00;
      default: nxt = 2'b01;
    endcase
  endfunction

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic sample_all(input string t1, input string t2, input string t3, input string t4);
    chk(clk_b, bs[1], t1, "basic clk_out");
    chk(ph_b, bs == 2'b10, t3, "basic phase_mark");
    chk(clk_h, hs[1] | hq, t2, "half clk_out");
    chk(ph_h, hs == 2'b10, t3, "half phase_mark");
    if (fvalid) begin
      chk(clk_f, fs[1], t4, "free clk_out");
      chk(ph_f, fs == 2'b10, t4, "free phase_mark");
    end
  endtask

  task automatic step(input string tag, input string ftag);
    string t1, t2, t3, t4;
    t1 = (tag == "") ? "R2" : tag;
    t2 = (tag == "") ? "R3" : tag;
    t3 = (tag == "") ? "R4" : tag;
    t4 = (ftag == "") ? "R2" : ftag;
    @(posedge clk);
    fs = nxt(fs);
    if (rst) begin bs = 2'b00; hs = 2'b00; hq = 1'b0; end
    else begin bs = nxt(bs); hs = nxt(hs); end
    #2 sample_all(t1, t2, t3, t4);
    #2 hq = rst ? 1'b0 : hs[1];
    #2 sample_all(t1, t2, t3, t4);
  endtask

  task automatic load(input logic [1:0] s);
    string t;
    t = (s == 2'b11) ? "R5" : "R6";
    rst = 1'b1;
    #0.5;
    fa = s[1];
    fb = s[0];
    force dut.qa_q = fa;      force dut.qb_q = fb;
    force dut_half.qa_q = fa; force dut_half.qb_q = fb;
    force dut_free.qa_q = fa; force dut_free.qb_q = fb;
    @(posedge clk);
    #1;
    release dut.qa_q;      release dut.qb_q;
    release dut_half.qa_q; release dut_half.qb_q;
    release dut_free.qa_q; release dut_free.qb_q;
    #0.5 rst = 1'b0;
    bs = s; hs = s; fs = s; hq = s[1]; fvalid = 1'b1;
    #4.5 sample_all(t, t, t, t);
  endtask

  task automatic reset_pulse(input int n);
    #1 rst = 1'b1;
    #0.5;
    bs = 2'b00; hs = 2'b00; hq = 1'b0;
    sample_all("R7", "R7", "R7", "R9");
    repeat (n) step("R7", "R9");
    #1 rst = 1'b0;
    step("R8", "R9");
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b0; fa = 1'b0; fb = 1'b0;
    bs = 2'b00; hs = 2'b00; fs = 2'b00; hq = 1'b0; fvalid = 1'b0;
    #1 rst = 1'b1;
    #2 sample_all("R7", "R7", "R7", "R9");
    @(posedge clk);
    #6;
    #1 rst = 1'b0;
    step("R8", "");
    repeat (9) step("R1", "");
    for (int s = 0; s < 4; s++) begin
      load(2'(s));
      repeat (3) step((s == 3) ? "R5" : "R6", (s == 3) ? "R5" : "R6");
      repeat (3) step("", "");
    end
    reset_pulse(2);
    for (int i = 0; i < 60; i++) begin
      case ($urandom % 3)
        0: load(2'($urandom % 4));
        1: reset_pulse(1 + int'($urandom % 3));
        default: repeat (1 + $urandom % 6) step("", "");
      endcase
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule